// File: doc/BRIEF.md
# Hardware Loop End Stall Generator

This block produces the fetch/decode hold for a DSP-style pipeline that runs a zero-overhead hardware loop. Every cycle in which the pipeline accepts an instruction, the block looks at that instruction's decoded class, its own address, and its branch target or return address. It compares them with the current loop-end address and the loop-active flag. When a change of flow lands on one of the last two addresses of the loop body, the instruction fetched after the loop wrap has to be held. The block also holds the next instruction when a conditional change of flow is not taken.

The hold is kept in a small down-counter, and `stall` is high while that counter is nonzero. While `stall` is high, `stall_addr` gives the address of the instruction being held. A trigger that arrives while a hold is still running does not add to it. The counter takes the larger of the cycles still left and the new request. Decoding, the loop counter and the system stack stay outside the block and reach it only as input signals. Every address computation wraps modulo 2^AW.

Top module: `loop_stall_gen`

## Requirements
- R1: With `loop_active` high, an accepted jump (class 1, or class 4 with `cond_false` low) whose `issue_target` equals `loop_end` raises `stall` for exactly LONG_HOLD (default 2) cycles, starting the cycle after acceptance, with `stall_addr` = `loop_end`+1.
- R2: With `loop_active` high, an accepted jump whose target equals `loop_end`−1 raises `stall` for SHORT_HOLD (default 1) cycle with `stall_addr` = `loop_end`+1. Any other target produces no stall.
- R3: With `loop_active` high, an accepted return-from-interrupt (class 2) whose `issue_target` equals `loop_end` stalls for LONG_HOLD cycles, and one that equals `loop_end`−1 stalls for SHORT_HOLD cycles. In both cases `stall_addr` = `loop_end`.
- R4: With `loop_active` high, an accepted stack-high read (class 3) whose own `issue_addr` equals `loop_end`−2 stalls for SHORT_HOLD cycles with `stall_addr` = `loop_end`+1. At any other address it produces no stall.
- R5: An accepted conditional change of flow (class 4) with `cond_false` high stalls for SHORT_HOLD cycles with `stall_addr` = `issue_addr`+1, whatever the value of `loop_active`.
- R6: With `loop_active` low, classes 1 to 3 and taken class 4 never stall. Class 0 never stalls. Inputs presented while `issue_valid` is low have no effect.
- R7: A trigger accepted while a hold is running sets the count to the larger of the cycles still left and the new request; it does not add them. On a tie, or when the new request is larger, `stall_addr` takes the new address.
- R8: All address offsets (`loop_end`±1, −2, `issue_addr`+1) wrap modulo 2^AW.
- R9: While `rst_n` is low at a clock edge, the counter is cleared and `stall` is low from that edge on. This also ends a hold that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is accepted this cycle |
| issue_class | input | 3 | Decoded class: 0 other, 1 jump, 2 return-from-interrupt, 3 stack-high read, 4 conditional change of flow |
| issue_addr | input | AW | Address of the accepted instruction |
| issue_target | input | AW | Jump target or return address |
| cond_false | input | 1 | Condition of a class-4 instruction evaluated false |
| loop_active | input | 1 | A hardware loop is running |
| loop_end | input | AW | Last address of the running loop |
| stall | output | 1 | Hold the fetch/decode stage |
| stall_addr | output | AW | Address of the instruction being held |

## Verification
The bench builds the block with AW = 8 and the default hold lengths of 2 and 1. The narrow address makes the wrap cases easy to reach: a loop ending at 0 puts its last-but-one address at 255 and its stack-read slot at 254. A second jump onto the loop end, issued one cycle after a first, shows the max rule directly, because the hold lasts three cycles in total rather than four. A reset raised in the middle of a hold, and triggers presented with the accept signal low, cover the clearing and ignoring cases.

// File: rtl/loop_stall_pkg.sv
// Package: shared class encoding and helpers for the loop-end stall generator.
// Assumes: issue_class is a 3-bit code decoded upstream; unused codes act as "other".
package loop_stall_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER  = 3'd0,
        CLS_JUMP   = 3'd1,
        CLS_RTI    = 3'd2,
        CLS_SSH_RD = 3'd3,
        CLS_CCOF   = 3'd4
    } insn_class_e;

    // Larger of two integer constants, used to size the hold counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsg_loop_rules.sv
// Module: lsg_loop_rules
// Works out the hold request raised by a change of flow near the end of an
// active hardware loop. The request comes from a jump or a taken conditional
// landing on loop_end or loop_end-1, from a return landing on either of those
// addresses, or from a stack-high read located at loop_end-2.
// Assumes: exactly one class per accepted instruction; arithmetic wraps at AW bits.
module lsg_loop_rules
    import loop_stall_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CW         = 2,
    parameter int LONG_HOLD  = 2,
    parameter int SHORT_HOLD = 1
) (
    input  logic          issue_valid,
    input  logic [2:0]    issue_class,
    input  logic [AW-1:0] issue_addr,
    input  logic [AW-1:0] issue_target,
    input  logic          cond_false,
    input  logic          loop_active,
    input  logic [AW-1:0] loop_end,
    output logic          req_hit,
    output logic [CW-1:0] req_cycles,
    output logic [AW-1:0] req_addr
);
    // Offsets below loop_end that are compared with the target: 0 and 1.
    localparam int NOFF = 2;

    logic [NOFF-1:0] tgt_near;        // tgt_near[i]: target == loop_end - i
    logic            ssh_slot;        // stack read sits at loop_end - 2
    logic            is_jump;
    logic            is_rti;
    logic            is_ssh;
    logic [AW-1:0]   after_end;

    // One comparator per tail offset of the loop body.
    for (genvar i = 0; i < NOFF; i++) begin : g_tail
        assign tgt_near[i] = (issue_target == (loop_end - AW'(i)));
    end

    assign ssh_slot  = (issue_addr == (loop_end - AW'(2)));
    assign after_end = loop_end + AW'(1);

    // Decode the class into the three loop-sensitive groups.
    always_comb begin
        is_jump = (issue_class == CLS_JUMP) ||
                  ((issue_class == CLS_CCOF) && !cond_false);
        is_rti  = (issue_class == CLS_RTI);
        is_ssh  = (issue_class == CLS_SSH_RD);
    end

    // Choose the length and the address of the held instruction.
    always_comb begin
        req_hit    = 1'b0;
        req_cycles = '0;
        req_addr   = after_end;
        if (issue_valid && loop_active) begin
            if (is_jump && tgt_near[0]) begin
                req_hit    = 1'b1;
                req_cycles = CW'(LONG_HOLD);
            end else if (is_jump && tgt_near[1]) begin
                req_hit    = 1'b1;
                req_cycles = CW'(SHORT_HOLD);
            end else if (is_rti && tgt_near[0]) begin
                req_hit    = 1'b1;
                req_cycles = CW'(LONG_HOLD);
                req_addr   = loop_end;
            end else if (is_rti && tgt_near[1]) begin
                req_hit    = 1'b1;
                req_cycles = CW'(SHORT_HOLD);
                req_addr   = loop_end;
            end else if (is_ssh && ssh_slot) begin
                req_hit    = 1'b1;
                req_cycles = CW'(SHORT_HOLD);
            end
        end
    end

endmodule

// File: rtl/lsg_cond_rule.sv
// Module: lsg_cond_rule
// Raises a hold request for the next sequential instruction when a
// conditional change of flow is not taken. Independent of the loop state.
// Assumes: cond_false is only meaningful for the conditional class.
module lsg_cond_rule
    import loop_stall_pkg::*;
#(
    parameter int AW         = 16,
    parameter int CW         = 2,
    parameter int SHORT_HOLD = 1
) (
    input  logic          issue_valid,
    input  logic [2:0]    issue_class,
    input  logic [AW-1:0] issue_addr,
    input  logic          cond_false,
    output logic          req_hit,
    output logic [CW-1:0] req_cycles,
    output logic [AW-1:0] req_addr
);
    // Untaken conditional: hold the fall-through instruction.
    always_comb begin
        req_hit    = issue_valid && (issue_class == CLS_CCOF) && cond_false;
        req_cycles = req_hit ? CW'(SHORT_HOLD) : '0;
        req_addr   = issue_addr + AW'(1);
    end

endmodule

// File: rtl/lsg_req_select.sv
// Module: lsg_req_select
// Combines NREQ hold requests into one by keeping the longest. On equal
// lengths the lower-numbered source wins.
// Assumes: requests that are not hit carry zero cycles.
module lsg_req_select #(
    parameter int AW   = 16,
    parameter int CW   = 2,
    parameter int NREQ = 2
) (
    input  logic [NREQ-1:0]         in_hit,
    input  logic [NREQ-1:0][CW-1:0] in_cycles,
    input  logic [NREQ-1:0][AW-1:0] in_addr,
    output logic                    out_hit,
    output logic [CW-1:0]           out_cycles,
    output logic [AW-1:0]           out_addr
);
    // Linear scan from the highest index down so that lower indices win ties.
    always_comb begin
        out_hit    = 1'b0;
        out_cycles = '0;
        out_addr   = in_addr[0];
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (in_hit[i] && (!out_hit || in_cycles[i] >= out_cycles)) begin
                out_hit    = 1'b1;
                out_cycles = in_cycles[i];
                out_addr   = in_addr[i];
            end
        end
    end

endmodule

// File: rtl/lsg_hold_counter.sv
// Module: lsg_hold_counter
// Down-counter that holds the pipeline. It loads on an accepted request and
// merges overlapping requests by taking the larger of the remaining and the
// requested cycles. It also keeps the tag of the held instruction.
// Assumes: synchronous active-low reset; req_cycles is nonzero when req_hit is high.
module lsg_hold_counter #(
    parameter int AW = 16,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_hit,
    input  logic [CW-1:0] req_cycles,
    input  logic [AW-1:0] req_addr,
    output logic          stall,
    output logic [AW-1:0] stall_addr
);
    logic [CW-1:0] cnt_q, cnt_d, remain;
    logic [AW-1:0] tag_q, tag_d;

    // Cycles still owed after the current one.
    always_comb begin
        remain = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
    end

    // Merge rule: keep the larger; the new request wins ties.
    always_comb begin
        cnt_d = remain;
        tag_d = tag_q;
        if (req_hit && (req_cycles >= remain)) begin
            cnt_d = req_cycles;
            tag_d = req_addr;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            tag_q <= tag_d;
        end
    end

    assign stall      = (cnt_q != '0);
    assign stall_addr = tag_q;

endmodule

// File: rtl/loop_stall_gen.sv
// Module: loop_stall_gen (top)
// End-of-loop stall generator. Feeds the accepted instruction to the loop
// rules and to the untaken-conditional rule, keeps the longer request, and
// drives the hold counter that produces stall and the held address.
// Assumes: inputs come from registered decode; stall_addr is only meaningful
// while stall is high.
module loop_stall_gen
    import loop_stall_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LONG_HOLD  = 2,
    parameter int SHORT_HOLD = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [2:0]    issue_class,
    input  logic [AW-1:0] issue_addr,
    input  logic [AW-1:0] issue_target,
    input  logic          cond_false,
    input  logic          loop_active,
    input  logic [AW-1:0] loop_end,
    output logic          stall,
    output logic [AW-1:0] stall_addr
);
    localparam int MAXH = imax(LONG_HOLD, SHORT_HOLD);
    localparam int CW   = $clog2(MAXH + 1);
    localparam int NREQ = 2;

    logic [NREQ-1:0]         src_hit;
    logic [NREQ-1:0][CW-1:0] src_cycles;
    logic [NREQ-1:0][AW-1:0] src_addr;
    logic                    sel_hit;
    logic [CW-1:0]           sel_cycles;
    logic [AW-1:0]           sel_addr;

    // Source 0: loop-tail rules.
    lsg_loop_rules #(.AW(AW), .CW(CW), .LONG_HOLD(LONG_HOLD), .SHORT_HOLD(SHORT_HOLD)) u_loop (
        .issue_valid (issue_valid),
        .issue_class (issue_class),
        .issue_addr  (issue_addr),
        .issue_target(issue_target),
        .cond_false  (cond_false),
        .loop_active (loop_active),
        .loop_end    (loop_end),
        .req_hit     (src_hit[0]),
        .req_cycles  (src_cycles[0]),
        .req_addr    (src_addr[0])
    );

    // Source 1: untaken conditional rule.
    lsg_cond_rule #(.AW(AW), .CW(CW), .SHORT_HOLD(SHORT_HOLD)) u_cond (
        .issue_valid(issue_valid),
        .issue_class(issue_class),
        .issue_addr (issue_addr),
        .cond_false (cond_false),
        .req_hit    (src_hit[1]),
        .req_cycles (src_cycles[1]),
        .req_addr   (src_addr[1])
    );

    // Keep the longest request of this cycle.
    lsg_req_select #(.AW(AW), .CW(CW), .NREQ(NREQ)) u_sel (
        .in_hit    (src_hit),
        .in_cycles (src_cycles),
        .in_addr   (src_addr),
        .out_hit   (sel_hit),
        .out_cycles(sel_cycles),
        .out_addr  (sel_addr)
    );

    // Hold counter and tag.
    lsg_hold_counter #(.AW(AW), .CW(CW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hit   (sel_hit),
        .req_cycles(sel_cycles),
        .req_addr  (sel_addr),
        .stall     (stall),
        .stall_addr(stall_addr)
    );

endmodule

// File: rtl/lsg_checker.sv
// Module: lsg_checker
// Port-level properties for loop_stall_gen, attached with bind below.
// Assumes: rst_n is driven low from time zero.
module lsg_checker
    import loop_stall_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LONG_HOLD = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic [2:0]    issue_class,
    input logic [AW-1:0] issue_addr,
    input logic [AW-1:0] issue_target,
    input logic          cond_false,
    input logic          loop_active,
    input logic [AW-1:0] loop_end,
    input logic          stall,
    input logic [AW-1:0] stall_addr
);
    localparam int QW = $clog2(LONG_HOLD + 2);

    logic [QW-1:0] quiet_run;   // stall cycles since the last accepted instruction

    // Count stall cycles with no accepted instruction since they began.
    always_ff @(posedge clk) begin
        if (!rst_n || issue_valid || !stall)
            quiet_run <= '0;
        else if (quiet_run != '1)
            quiet_run <= quiet_run + QW'(1);
    end

    // R1: a jump onto loop_end from idle holds loop_end+1.
    p_jump_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && loop_active && !stall && issue_class == CLS_JUMP &&
         issue_target == loop_end)
        |=> (stall && stall_addr == $past(loop_end) + AW'(1)));

    // R3: a return onto loop_end holds loop_end itself.
    p_rti_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && loop_active && !stall && issue_class == CLS_RTI &&
         issue_target == loop_end)
        |=> (stall && stall_addr == $past(loop_end)));

    // R5: an untaken conditional holds the fall-through address.
    p_cond_false_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall && issue_class == CLS_CCOF && cond_false)
        |=> (stall && stall_addr == $past(issue_addr) + AW'(1)));

    // R6: with no loop running, only class 4 can start a hold.
    p_no_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (!issue_valid || (!loop_active && issue_class != CLS_CCOF)))
        |=> !stall);

    // R7: without new triggers a hold never outlasts the long request.
    p_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (quiet_run < QW'(LONG_HOLD)));

    // R9: a reset edge leaves stall low.
    p_reset_r9: assert property (@(posedge clk) !rst_n |=> !stall);

endmodule

bind loop_stall_gen lsg_checker #(.AW(AW), .LONG_HOLD(LONG_HOLD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_class (issue_class),
    .issue_addr  (issue_addr),
    .issue_target(issue_target),
    .cond_false  (cond_false),
    .loop_active (loop_active),
    .loop_end    (loop_end),
    .stall       (stall),
    .stall_addr  (stall_addr)
);

// File: tb/sim_loop_stall_gen.sv
// Directed bench for loop_stall_gen, AW = 8, default hold lengths.
module sim_loop_stall_gen;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [2:0]    issue_class = 3'd0;
    logic [AW-1:0] issue_addr = '0;
    logic [AW-1:0] issue_target = '0;
    logic          cond_false = 1'b0;
    logic          loop_active = 1'b0;
    logic [AW-1:0] loop_end = '0;
    logic          stall;
    logic [AW-1:0] stall_addr;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    loop_stall_gen #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_class(issue_class), .issue_addr(issue_addr),
        .issue_target(issue_target), .cond_false(cond_false),
        .loop_active(loop_active), .loop_end(loop_end),
        .stall(stall), .stall_addr(stall_addr)
    );

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Present one instruction for one cycle (inputs change at negedge).
    task automatic present(input logic v, input logic [2:0] cls, input int a,
                           input int t, input logic cf, input logic act, input int la);
        @(negedge clk);
        issue_valid  = v;
        issue_class  = cls;
        issue_addr   = AW'(a);
        issue_target = AW'(t);
        cond_false   = cf;
        loop_active  = act;
        loop_end     = AW'(la);
    endtask

    // Count consecutive stall cycles from the current negedge onward.
    task automatic measure(output int len, output int tag);
        len = 0;
        tag = -1;
        for (int k = 0; k < 6; k++) begin
            if (!stall) break;
            if (len == 0) tag = int'(stall_addr);
            len++;
            @(negedge clk);
        end
    endtask

    // One scenario: a single instruction, then check length and tag of the hold.
    task automatic run_case(input string req, input logic v, input logic [2:0] cls,
                            input int a, input int t, input logic cf, input logic act,
                            input int la, input int exp_len, input int exp_tag);
        int len, tag;
        present(v, cls, a, t, cf, act, la);
        @(negedge clk);
        issue_valid = 1'b0;
        measure(len, tag);
        check({req, " length"}, len, exp_len);
        if (exp_len > 0) check({req, " address"}, tag, exp_tag);
        repeat (2) @(negedge clk);
    endtask

    // R7: two jumps onto loop_end back to back give 3 cycles in total, not 4.
    task automatic merge_case();
        int len, tag;
        present(1'b1, 3'd1, 10, 40, 1'b0, 1'b1, 40);
        present(1'b1, 3'd1, 11, 40, 1'b0, 1'b1, 40);
        check("R7 first hold cycle", int'(stall), 1);
        @(negedge clk);
        issue_valid = 1'b0;
        measure(len, tag);
        check("R7 total length max-merge", len + 1, 3);
        check("R7 address", tag, 41);
        repeat (2) @(negedge clk);
    endtask

    // R9: reset in the middle of a hold clears it.
    task automatic reset_case();
        present(1'b1, 3'd1, 10, 40, 1'b0, 1'b1, 40);
        @(negedge clk);
        issue_valid = 1'b0;
        check("R9 hold started", int'(stall), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 cleared by reset", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 stays idle", int'(stall), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", int'(stall), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case("R1 jump to end",           1, 3'd1, 5,  40, 0, 1, 40, 2, 41);
        run_case("R1 taken cond to end",     1, 3'd4, 5,  40, 0, 1, 40, 2, 41);
        run_case("R2 jump to end-1",         1, 3'd1, 5,  39, 0, 1, 40, 1, 41);
        run_case("R2 jump to end-2",         1, 3'd1, 5,  38, 0, 1, 40, 0, 0);
        run_case("R3 return to end",         1, 3'd2, 5,  40, 0, 1, 40, 2, 40);
        run_case("R3 return to end-1",       1, 3'd2, 5,  39, 0, 1, 40, 1, 40);
        run_case("R4 stack read at end-2",   1, 3'd3, 38, 0,  0, 1, 40, 1, 41);
        run_case("R4 stack read at end-3",   1, 3'd3, 37, 0,  0, 1, 40, 0, 0);
        run_case("R5 untaken cond in loop",  1, 3'd4, 20, 40, 1, 1, 40, 1, 21);
        run_case("R5 untaken cond no loop",  1, 3'd4, 90, 0,  1, 0, 40, 1, 91);
        run_case("R6 jump no loop",          1, 3'd1, 5,  40, 0, 0, 40, 0, 0);
        run_case("R6 return no loop",        1, 3'd2, 5,  40, 0, 0, 40, 0, 0);
        run_case("R6 other class",           1, 3'd0, 38, 40, 0, 1, 40, 0, 0);
        run_case("R6 not accepted",          0, 3'd1, 5,  40, 0, 1, 40, 0, 0);
        run_case("R8 wrap end-1 at zero",    1, 3'd1, 5,  255, 0, 1, 0, 1, 1);
        run_case("R8 wrap end-2 at zero",    1, 3'd3, 254, 0, 0, 1, 0, 1, 1);
        run_case("R8 wrap end+1 at top",     1, 3'd1, 5,  255, 0, 1, 255, 2, 0);
        run_case("R8 wrap fall-through",     1, 3'd4, 255, 0, 1, 0, 40, 1, 0);
        merge_case();
        reset_case();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule